// File: doc/BRIEF.md
# Edge-Recording GPIO Bank

This block is a memory-mapped bank of general-purpose pins (62 by default). Software sets the direction and output level of each pin, and reads back one level view per pin. When a pin drives, the view shows the driven level. When a pin is an input, the view shows the synchronised pad level. Every pad input passes through a synchroniser. Edges of the synchronised level are recorded in two families of sticky status words.

The "assert" family records the edge that the pin's polarity bit selects. The "deassert" family records the opposite edge. Each family has its own level interrupt output, gated per pin by an interrupt-enable bit.

Status words hold 31 pins each. Bit 0 of a status word holds no pin. On a write, bit 0 selects whether the other bits written as 1 are set or cleared. This lets software set or clear any group of events in one write without a read-modify-write.

Register access uses a plain word interface. A write takes effect at the clock edge where `wr_en` is high. A read is combinational from `rd_addr`.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register word reads 0. `gpio_oe` is all 0 (every pin an input), both interrupt outputs are low, and the polarity is 0.
- R2: With the default sizes the word map is: direction 0-1, output data 2-3, level view 4-5, interrupt enable 6-7, polarity 8-9, assert status 10-11, deassert status 12-13. In the direction, output, view, enable and polarity families, pin p sits in word p/32 at bit p mod 32. `gpio_oe` follows the direction bits (1 = drive) and `gpio_out` follows the output-data bits, one cycle after the write.
- R3: A level-view bit returns the output-data bit when the pin's direction bit is 1. When the direction bit is 0, it returns the synchronised pad level.
- R4: In a status word, pin p sits in word p/31 of its family at bit (p mod 31)+1. Bit 0 always reads 0. Pin 30 is bit 31 of word 0, pin 31 is bit 1 of word 1, and pin 61 is bit 31 of word 1.
- R5: A status write with bit 0 = 1 sets every other bit written as 1. Bits written as 0 keep their value.
- R6: A status write with bit 0 = 0 clears every other bit written as 1. Bits written as 0 keep their value.
- R7: With polarity 1, a rising edge sets the assert status bit and a falling edge sets the deassert status bit. With polarity 0 the roles swap.
- R8: A pad change applied before clock edge k shows in the level view after edge k+1. It shows in status after edge k+2.
- R9: `irq_assert` (`irq_deassert`) is high exactly while some assert (deassert) status bit is set and its pin's enable bit is 1. A set status bit with enable 0 leaves the output low.
- R10: When an edge is recorded in the same cycle as a write that clears its status bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| gpio_in | input | NPINS | Pad input levels, asynchronous |
| gpio_out | output | NPINS | Pad output levels |
| gpio_oe | output | NPINS | Pad output enables, 1 = drive |
| irq_assert | output | 1 | Level interrupt from enabled assert status |
| irq_deassert | output | 1 | Level interrupt from enabled deassert status |

## Verification
The hardest case to reach is the collision between a clear write and a fresh edge on the same status bit. The edge exists inside the block for a single cycle, two edges after the pad change. The bench first records an edge on the pin so that the bit is already set. It then toggles the pad at a falling clock edge and counts exactly two rising edges. It places the clearing write so that it is captured on the same edge that records the new event, then reads the bit back.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants, register-kind encoding and sizing helpers
// for the edge-recording GPIO bank.
package gpio_bank_pkg;
    localparam int WORD_W   = 32;
    localparam int GRP_PINS = 31;

    typedef enum logic [2:0] {
        K_DIR,
        K_DOUT,
        K_VIEW,
        K_IEN,
        K_POL,
        K_AST,
        K_DST,
        K_NONE
    } reg_kind_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Splits a word address into a register kind and a word index within
// that kind. Assumes the families are laid out back to back in the
// order direction, output, view, enable, polarity, assert, deassert.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int NDW    = 2,
    parameter int NSG    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [ADDR_W-1:0] idx
);
    localparam int B_DOUT = NDW;
    localparam int B_VIEW = 2 * NDW;
    localparam int B_IEN  = 3 * NDW;
    localparam int B_POL  = 4 * NDW;
    localparam int B_AST  = 5 * NDW;
    localparam int B_DST  = 5 * NDW + NSG;
    localparam int B_END  = 5 * NDW + 2 * NSG;

    // Range compare against each family base.
    always_comb begin
        int a;
        a    = int'(addr);
        kind = K_NONE;
        idx  = '0;
        if (a < B_DOUT) begin
            kind = K_DIR;  idx = ADDR_W'(a);
        end else if (a < B_VIEW) begin
            kind = K_DOUT; idx = ADDR_W'(a - B_DOUT);
        end else if (a < B_IEN) begin
            kind = K_VIEW; idx = ADDR_W'(a - B_VIEW);
        end else if (a < B_POL) begin
            kind = K_IEN;  idx = ADDR_W'(a - B_IEN);
        end else if (a < B_AST) begin
            kind = K_POL;  idx = ADDR_W'(a - B_POL);
        end else if (a < B_DST) begin
            kind = K_AST;  idx = ADDR_W'(a - B_AST);
        end else if (a < B_END) begin
            kind = K_DST;  idx = ADDR_W'(a - B_DST);
        end
    end
endmodule

// File: rtl/gpio_sync_edge.sv
// Module: gpio_sync_edge
// Brings asynchronous pad levels into the clock domain through a flop
// chain, then flags edges against a one-cycle-delayed copy. The
// polarity bit of a pin decides which edge counts as assert.
// Assumes pad inputs are quasi-static relative to the clock.
module gpio_sync_edge #(
    parameter int N           = 62,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] evt_assert_o,
    output logic [N-1:0] evt_deassert_o
);
    logic [N-1:0] stage_q [SYNC_STAGES];
    logic [N-1:0] prev_q;
    logic [N-1:0] rise, fall;

    // Synchroniser chain and delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= pin_i;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[SYNC_STAGES-1];
        end
    end

    // Edge classification by polarity.
    always_comb begin
        level_o        = stage_q[SYNC_STAGES-1];
        rise           = level_o & ~prev_q;
        fall           = ~level_o & prev_q;
        evt_assert_o   = (pol_i & rise) | (~pol_i & fall);
        evt_deassert_o = (pol_i & fall) | (~pol_i & rise);
    end
endmodule

// File: rtl/gpio_status_word.sv
// Module: gpio_status_word
// One sticky status word of 31 pins. Bit 0 of a write selects set
// (1) or clear (0) for the other bits written as 1. An incoming event
// always wins over a clear. Only the lowest NV bits hold real pins.
module gpio_status_word
    import gpio_bank_pkg::*;
#(
    parameter int NV = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_hit,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [GRP_PINS-1:0] evt_i,
    output logic [GRP_PINS-1:0] stat_o
);
    localparam logic [GRP_PINS-1:0] VALID =
        (NV >= GRP_PINS) ? {GRP_PINS{1'b1}} : GRP_PINS'((64'd1 << NV) - 64'd1);

    logic [GRP_PINS-1:0] stat_q, stat_d;

    // Next state: apply the write, then OR in fresh events.
    always_comb begin
        stat_d = stat_q;
        if (wr_hit) begin
            if (wr_data[0]) stat_d = stat_q | wr_data[WORD_W-1:1];
            else            stat_d = stat_q & ~wr_data[WORD_W-1:1];
        end
        stat_d = (stat_d | evt_i) & VALID;
    end

    // Status storage.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/gpio_edge_bank.sv
// Module: gpio_edge_bank
// Top of the GPIO bank. Holds the direction, output, enable and
// polarity words, one level view per pin, and two families of edge
// status words with one level interrupt per family.
// Assumes single-cycle writes and a combinational read path.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 62,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NPINS-1:0]  gpio_in,
    output logic [NPINS-1:0]  gpio_out,
    output logic [NPINS-1:0]  gpio_oe,
    output logic              irq_assert,
    output logic              irq_deassert
);
    localparam int NDW     = ceil_div(NPINS, WORD_W);
    localparam int NSG     = ceil_div(NPINS, GRP_PINS);
    localparam int DW_BITS = NDW * WORD_W;
    localparam int SG_BITS = NSG * GRP_PINS;
    localparam logic [DW_BITS-1:0] PIN_MASK = DW_BITS'({NPINS{1'b1}});

    reg_kind_e         wr_kind, rd_kind;
    logic [ADDR_W-1:0] wr_idx, rd_idx;

    logic [DW_BITS-1:0] dir_q, dout_q, ien_q, pol_q, view;
    logic [NPINS-1:0]   lvl, evt_a, evt_d;
    logic [SG_BITS-1:0] evt_a_pad, evt_d_pad, ie_pad, ast_flat, dst_flat;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .NDW(NDW), .NSG(NSG)) u_wdec (
        .addr(wr_addr), .kind(wr_kind), .idx(wr_idx)
    );
    gpio_addr_decode #(.ADDR_W(ADDR_W), .NDW(NDW), .NSG(NSG)) u_rdec (
        .addr(rd_addr), .kind(rd_kind), .idx(rd_idx)
    );

    // Control word storage, one 32-bit slice per word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            ien_q  <= '0;
            pol_q  <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NDW; w++) begin
                if (wr_idx == ADDR_W'(w)) begin
                    case (wr_kind)
                        K_DIR:   dir_q [w*WORD_W +: WORD_W] <= wr_data;
                        K_DOUT:  dout_q[w*WORD_W +: WORD_W] <= wr_data;
                        K_IEN:   ien_q [w*WORD_W +: WORD_W] <= wr_data;
                        K_POL:   pol_q [w*WORD_W +: WORD_W] <= wr_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    gpio_sync_edge #(.N(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(gpio_in), .pol_i(pol_q[NPINS-1:0]),
        .level_o(lvl), .evt_assert_o(evt_a), .evt_deassert_o(evt_d)
    );

    // Re-index per-pin vectors onto the 31-pin status grid.
    always_comb begin
        evt_a_pad = SG_BITS'(evt_a);
        evt_d_pad = SG_BITS'(evt_d);
        ie_pad    = SG_BITS'(ien_q[NPINS-1:0]);
    end

    for (genvar g = 0; g < NSG; g++) begin : g_grp
        localparam int NV = (NPINS - g * GRP_PINS >= GRP_PINS) ?
                            GRP_PINS : (NPINS - g * GRP_PINS);
        gpio_status_word #(.NV(NV)) u_ast (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(wr_en && wr_kind == K_AST && wr_idx == ADDR_W'(g)),
            .wr_data(wr_data), .evt_i(evt_a_pad[g*GRP_PINS +: GRP_PINS]),
            .stat_o(ast_flat[g*GRP_PINS +: GRP_PINS])
        );
        gpio_status_word #(.NV(NV)) u_dst (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(wr_en && wr_kind == K_DST && wr_idx == ADDR_W'(g)),
            .wr_data(wr_data), .evt_i(evt_d_pad[g*GRP_PINS +: GRP_PINS]),
            .stat_o(dst_flat[g*GRP_PINS +: GRP_PINS])
        );
    end

    // Level view: driven value for outputs, synchronised pad for inputs.
    assign view = ((dir_q & dout_q) | (~dir_q & DW_BITS'(lvl))) & PIN_MASK;

    // Combinational read multiplexer.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NDW; w++) begin
            if (rd_idx == ADDR_W'(w)) begin
                case (rd_kind)
                    K_DIR:   rd_data = dir_q [w*WORD_W +: WORD_W];
                    K_DOUT:  rd_data = dout_q[w*WORD_W +: WORD_W];
                    K_VIEW:  rd_data = view  [w*WORD_W +: WORD_W];
                    K_IEN:   rd_data = ien_q [w*WORD_W +: WORD_W];
                    K_POL:   rd_data = pol_q [w*WORD_W +: WORD_W];
                    default: ;
                endcase
            end
        end
        for (int g = 0; g < NSG; g++) begin
            if (rd_idx == ADDR_W'(g)) begin
                if (rd_kind == K_AST) rd_data = {ast_flat[g*GRP_PINS +: GRP_PINS], 1'b0};
                if (rd_kind == K_DST) rd_data = {dst_flat[g*GRP_PINS +: GRP_PINS], 1'b0};
            end
        end
    end

    // Pad drive and level interrupts.
    assign gpio_out     = dout_q[NPINS-1:0];
    assign gpio_oe      = dir_q[NPINS-1:0];
    assign irq_assert   = |(ast_flat & ie_pad);
    assign irq_deassert = |(dst_flat & ie_pad);
endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Module: gpio_edge_bank_chk
// Property checker bound into gpio_edge_bank. It watches the register
// port, the pad drive, the interrupt outputs and the event and status
// vectors that separate submodules drive. Assumes NPINS >= 32.
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 62,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                wr_en,
    input logic [ADDR_W-1:0]                   wr_addr,
    input logic [31:0]                         wr_data,
    input logic [ADDR_W-1:0]                   rd_addr,
    input logic [31:0]                         rd_data,
    input logic [NPINS-1:0]                    gpio_oe,
    input logic                                irq_assert,
    input logic                                irq_deassert,
    input logic [ceil_div(NPINS,31)*31-1:0]    ast_flat,
    input logic [ceil_div(NPINS,31)*31-1:0]    dst_flat,
    input logic [ceil_div(NPINS,31)*31-1:0]    evt_a_pad,
    input logic [ceil_div(NPINS,31)*31-1:0]    evt_d_pad
);
    localparam int NDW   = ceil_div(NPINS, WORD_W);
    localparam int NSG   = ceil_div(NPINS, GRP_PINS);
    localparam int B_AST = 5 * NDW;
    localparam int B_END = 5 * NDW + 2 * NSG;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gpio_oe == '0 && !irq_assert && !irq_deassert));

    p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> gpio_oe[31:0] == $past(wr_data));

    p_bit0_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) >= B_AST && int'(rd_addr) < B_END) |-> !rd_data[0]);

    p_set_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(B_AST) && wr_data[0])
        |=> (ast_flat[30:0] & $past(wr_data[31:1])) == $past(wr_data[31:1]));

    p_hold_ast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && evt_a_pad == '0) |=> $stable(ast_flat));

    p_hold_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && evt_d_pad == '0) |=> $stable(dst_flat));

    p_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(B_AST) && !wr_data[0] && evt_a_pad[30:0] == '0)
        |=> (ast_flat[30:0] & $past(wr_data[31:1])) == '0);

    p_irq_a_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_assert) |-> ($past(wr_en) || $past(evt_a_pad != '0)));

    p_irq_d_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_deassert) |-> ($past(wr_en) || $past(evt_d_pad != '0)));

    p_event_kept_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ast_flat & $past(evt_a_pad)) == $past(evt_a_pad));

    p_event_kept_d_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dst_flat & $past(evt_d_pad)) == $past(evt_d_pad));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
// Directed bench for gpio_edge_bank: one task per scenario.
module gpio_edge_bank_bench;
    localparam int NP = 62;
    // Word map from R2.
    localparam int A_DIR = 0, A_DOUT = 2, A_VIEW = 4, A_IEN = 6, A_POL = 8;
    localparam int A_AST = 10, A_DST = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [4:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] gpio_in = '0;
    logic [NP-1:0] gpio_out, gpio_oe;
    logic          irq_assert, irq_deassert;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_bank u_gpio_edge_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .irq_assert(irq_assert), .irq_deassert(irq_deassert)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, input string tag, input logic [31:0] exp);
        rd_addr = 5'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_status();
        wr(A_AST, 32'hFFFF_FFFE); wr(A_AST + 1, 32'hFFFF_FFFE);
        wr(A_DST, 32'hFFFF_FFFE); wr(A_DST + 1, 32'hFFFF_FFFE);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 14; a++) rd(a, "R1 reset word", 32'h0);
        chk("R1 oe low", 32'(gpio_oe[31:0]) | 32'(gpio_oe[NP-1:32]), 32'h0);
        chk("R1 irqs low", {30'h0, irq_assert, irq_deassert}, 32'h0);
    endtask

    task automatic t_direction();
        wr(A_DIR, 32'h0000_00F0);
        wr(A_DOUT, 32'h0000_00A5);
        wr(A_DIR + 1, 32'h2000_0001);
        chk("R2 oe word0", gpio_oe[31:0], 32'h0000_00F0);
        chk("R2 oe word1", 32'(gpio_oe[NP-1:32]), 32'h2000_0001);
        chk("R2 out word0", gpio_out[31:0], 32'h0000_00A5);
        rd(A_DIR + 1, "R2 dir readback", 32'h2000_0001);
    endtask

    task automatic t_view();
        gpio_in[31:0] = 32'h0F0F_0F0F;
        idle(4);
        // Bits 4..7 driven (A5 -> 1010 there), the rest from the pad.
        rd(A_VIEW, "R3 mixed view", (32'h0F0F_0F0F & ~32'h0000_00F0) | (32'h0000_00A5 & 32'h0000_00F0));
        wr(A_DIR, 32'h0);
        wr(A_DIR + 1, 32'h0);
        rd(A_VIEW, "R3 input view", 32'h0F0F_0F0F);
        gpio_in = '0;
        idle(4);
        clear_status();
        rd(A_DST, "R6 cleared", 32'h0);
        rd(A_AST, "R6 cleared", 32'h0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        gpio_in[3] = 1'b1;
        @(negedge clk);
        rd(A_VIEW, "R8 view after 1 edge", 32'h0);
        @(negedge clk);
        rd(A_VIEW, "R8 view after 2 edges", 32'h0000_0008);
        rd(A_DST, "R8 status after 2 edges", 32'h0);
        @(negedge clk);
        rd(A_DST, "R8 status after 3 edges", 32'h0000_0010);
        rd(A_AST, "R7 pol0 rise not assert", 32'h0);
        gpio_in[3] = 1'b0;
        idle(4);
        rd(A_AST, "R7 pol0 fall is assert", 32'h0000_0010);
        clear_status();
    endtask

    task automatic t_mapping();
        gpio_in[30] = 1'b1; gpio_in[31] = 1'b1; gpio_in[61] = 1'b1;
        idle(4);
        rd(A_DST, "R4 pin30 word0 bit31", 32'h8000_0000);
        rd(A_DST + 1, "R4 pins31,61 word1", 32'h8000_0002);
        rd(A_AST + 1, "R7 no assert on rise", 32'h0);
        gpio_in[30] = 1'b0; gpio_in[31] = 1'b0; gpio_in[61] = 1'b0;
        idle(4);
        rd(A_AST, "R4 fall pin30", 32'h8000_0000);
        rd(A_AST + 1, "R4 fall pins31,61", 32'h8000_0002);
        clear_status();
    endtask

    task automatic t_polarity();
        wr(A_POL, 32'h0000_0020);      // pin 5
        wr(A_POL + 1, 32'h0000_0100);  // pin 40
        gpio_in[5] = 1'b1; gpio_in[40] = 1'b1;
        idle(4);
        rd(A_AST, "R7 pol1 rise pin5", 32'h0000_0040);
        rd(A_DST, "R7 pol1 rise no deassert", 32'h0);
        rd(A_AST + 1, "R7 pol1 rise pin40", 32'h0000_0400);
        gpio_in[5] = 1'b0; gpio_in[40] = 1'b0;
        idle(4);
        rd(A_DST, "R7 pol1 fall pin5", 32'h0000_0040);
        rd(A_DST + 1, "R7 pol1 fall pin40", 32'h0000_0400);
        wr(A_POL, 32'h0); wr(A_POL + 1, 32'h0);
        clear_status();
    endtask

    task automatic t_setclear();
        wr(A_AST, 32'h0000_0013);
        rd(A_AST, "R5 set bits 1,4", 32'h0000_0012);
        wr(A_AST, 32'h0000_0101);
        rd(A_AST, "R5 set keeps others", 32'h0000_0112);
        wr(A_AST, 32'h0000_0010);
        rd(A_AST, "R6 clear bit 4", 32'h0000_0102);
        wr(A_AST, 32'h0000_0000);
        rd(A_AST, "R6 zero write no change", 32'h0000_0102);
        wr(A_AST, 32'h0000_0001);
        rd(A_AST, "R5 bit0-only write no change", 32'h0000_0102);
        clear_status();
    endtask

    task automatic t_irq();
        wr(A_AST, 32'h0000_0003);      // pin 0
        chk("R9 disabled stays low", {31'h0, irq_assert}, 32'h0);
        wr(A_IEN, 32'h0000_0001);
        chk("R9 enabled raises", {31'h0, irq_assert}, 32'h1);
        chk("R9 other line low", {31'h0, irq_deassert}, 32'h0);
        wr(A_DST + 1, 32'h0000_0401);  // pin 40
        chk("R9 pin40 disabled", {31'h0, irq_deassert}, 32'h0);
        wr(A_IEN + 1, 32'h0000_0100);
        chk("R9 pin40 enabled", {31'h0, irq_deassert}, 32'h1);
        idle(3);
        chk("R9 level holds", {30'h0, irq_assert, irq_deassert}, 32'h3);
        wr(A_AST, 32'h0000_0002);
        chk("R9 cleared drops", {31'h0, irq_assert}, 32'h0);
        wr(A_DST + 1, 32'h0000_0400);
        chk("R9 cleared drops", {31'h0, irq_deassert}, 32'h0);
        wr(A_IEN, 32'h0); wr(A_IEN + 1, 32'h0);
    endtask

    task automatic t_collision();
        @(negedge clk);
        gpio_in[7] = 1'b1;
        idle(4);
        rd(A_DST, "R10 setup rise", 32'h0000_0100);
        gpio_in[7] = 1'b0;
        idle(4);
        gpio_in[7] = 1'b1;             // at a falling edge
        @(negedge clk);
        @(negedge clk);                // event now live for one cycle
        wr_en = 1'b1; wr_addr = 5'(A_DST); wr_data = 32'h0000_0100;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_DST, "R10 set wins over clear", 32'h0000_0100);
        wr(A_DST, 32'h0000_0100);
        rd(A_DST, "R6 clear without edge", 32'h0);
        gpio_in[7] = 1'b0;
        idle(4);
        clear_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_view();
        t_latency();
        t_mapping();
        t_polarity();
        t_setclear();
        t_irq();
        t_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule